// File: doc/BRIEF.md
# Banked RAM Crossbar with Per-Bank Round-Robin Arbitration

This block joins a set of requester ports to a set of independent on-chip RAM banks. Each bank is a 64-bit wide synchronous memory. In every cycle each port may offer one access: a byte address, a size code, a read/write flag and right-justified write data. The top bits of the address pick a bank, afresh on each cycle. Ports that go to different banks are all served in that same cycle, whether their accesses are narrow or wide.

When more than one port goes to the same bank, an arbiter for that bank grants one of them. It picks the first requester at or after its rotating priority pointer, then moves the pointer to the port just after the one it granted. Every port that loses sees a stall in that cycle and keeps its request in place until it is granted.

Byte enables come from the low three address bits and the size code. An access that would run past the end of its 64-bit word is refused with an error flag and has no effect. Read data comes back one clock edge after the grant, shifted down to bit 0 and zero-filled above the access width, together with a valid strobe on that port.

Top module: `banked_ram_xbar`

## Requirements
- R1: The bank is chosen from the top address bits, addr[12:11] at default parameters; the word within the bank is addr[10:3]. Data written through one port is read back through any other port from that same bank and word, and other banks are left unchanged.
- R2: Ports that target different banks in the same cycle all get their grant in that cycle, and none of them stalls.
- R3: The size codes 0, 1, 2 and 3 select 1, 2, 4 and 8 bytes. A write changes only those bytes, starting at byte offset addr[2:0] within the 64-bit word, and takes its data from the low end of req_wdata.
- R4: When several ports target one bank, exactly one of them is granted and every other one of them sees req_stall high in that cycle.
- R5: Each bank arbitrates by round-robin: after it grants port g, port g+1 (modulo the port count) has the highest priority. When all ports keep requesting the same bank, the grants come out in ascending cyclic order.
- R6: A port that holds its request is granted within NUM_PORTS cycles, so while all ports contend, each of them is granted once in every NUM_PORTS consecutive cycles.
- R7: A granted read raises rsp_valid for that port after the next clock edge. rsp_rdata then holds the addressed bytes shifted down to bit 0, with the bits above the access width set to zero. A granted write raises no rsp_valid.
- R8: When addr[2:0] plus the access size in bytes is greater than 8, req_err is high in that same cycle. The access is not stalled, is not performed, changes no memory and gives no response.
- R9: While reset is held and after it ends, with no requests present, rsp_valid, req_stall and req_err are all low. Every bank's priority pointer starts at port 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | NUM_PORTS | Access request, one bit per port |
| req_write | input | NUM_PORTS | 1 = write, 0 = read, per port |
| req_size | input | 2*NUM_PORTS | Size code per port: 0=8, 1=16, 2=32, 3=64 bits |
| req_addr | input | ADDR_W*NUM_PORTS | Byte address per port |
| req_wdata | input | 64*NUM_PORTS | Right-justified write data per port |
| req_stall | output | NUM_PORTS | Request lost arbitration in this cycle; hold it |
| req_err | output | NUM_PORTS | Request crosses a 64-bit word and is refused |
| rsp_valid | output | NUM_PORTS | Read data valid, one cycle after the grant |
| rsp_rdata | output | 64*NUM_PORTS | Right-justified, zero-extended read data per port |

## Verification
The grant, stall and error flags are combinational in the cycle of the request. The bench checks them 1 ns after it drives inputs at the falling edge, before the rising edge that acts on them. A write takes effect at the rising edge of its grant. Read data and rsp_valid appear after that same rising edge, so the bench samples them at the next falling edge. In the contention test, each sample checks the previous cycle's winner for its returned data and the current cycle's winner for its stall pattern.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
    localparam int LANE_BYTES = 8;
    localparam int LANE_W     = 64;
    localparam int OFF_W      = 3;

    typedef enum logic [1:0] {
        ACC_BYTE = 2'd0,
        ACC_HALF = 2'd1,
        ACC_WORD = 2'd2,
        ACC_DWORD = 2'd3
    } acc_size_e;
endpackage

// File: rtl/xbar_port_decode.sv
module xbar_port_decode
    import xbar_pkg::*;
#(
    parameter int ADDR_W  = 13,
    parameter int BANK_W  = 2,
    parameter int WORD_AW = 8
) (
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [1:0]          size_i,
    input  logic [LANE_W-1:0]   wdata_i,
    output logic [BANK_W-1:0]   bank_o,
    output logic [WORD_AW-1:0]  word_o,
    output logic [LANE_BYTES-1:0] be_o,
    output logic [LANE_W-1:0]   lane_o,
    output logic                err_o
);
    logic [OFF_W-1:0] off;
    logic [3:0]       nbytes;
    logic [15:0]      be_wide;

    always_comb begin
        off     = addr_i[OFF_W-1:0];
        nbytes  = 4'd1 << size_i;
        err_o   = ({1'b0, off} + nbytes) > 4'd8;
        be_wide = ((16'd1 << nbytes) - 16'd1) << off;
        be_o    = be_wide[LANE_BYTES-1:0];
        lane_o  = wdata_i << {off, 3'b000};
        bank_o  = addr_i[ADDR_W-1 -: BANK_W];
        word_o  = addr_i[OFF_W +: WORD_AW];
    end

    always_comb begin
        if (!$isunknown({addr_i, size_i}) && !err_o)
            AST_BE_WIDTH: assert ($countones(be_o) == (1 << size_i)); // R3
    end
endmodule

// File: rtl/xbar_rr_arbiter.sv
module xbar_rr_arbiter #(
    parameter int NUM_PORTS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PORTS-1:0] req_i,
    output logic [NUM_PORTS-1:0] gnt_o
);
    localparam int PTR_W = $clog2(NUM_PORTS);

    typedef struct packed {
        logic [PTR_W-1:0] ptr;
    } arb_state_t;

    arb_state_t st_d, st_q;

    always_comb begin : arb_pick
        int   idx;
        logic found;
        st_d  = st_q;
        gnt_o = '0;
        found = 1'b0;
        idx   = 0;
        for (int k = 0; k < NUM_PORTS; k++) begin
            idx = (int'(st_q.ptr) + k) % NUM_PORTS;
            if (!found && req_i[idx]) begin
                found      = 1'b1;
                gnt_o[idx] = 1'b1;
                st_d.ptr   = PTR_W'((idx + 1) % NUM_PORTS);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gnt_o)); // R4
    AST_GRANT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n) (gnt_o & ~req_i) == '0); // R4
    AST_BUSY_GRANTS: assert property (@(posedge clk) disable iff (!rst_n) (|req_i) |-> (|gnt_o)); // R4

    logic [PTR_W:0] wait_q [NUM_PORTS];
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_wait
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                     wait_q[p] <= '0;
            else if (req_i[p] && !gnt_o[p]) wait_q[p] <= wait_q[p] + 1'b1;
            else                            wait_q[p] <= '0;
        end
        AST_BOUNDED_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
            int'(wait_q[p]) < NUM_PORTS); // R6
    end
endmodule

// File: rtl/xbar_bank_ram.sv
module xbar_bank_ram
    import xbar_pkg::*;
#(
    parameter int WORDS = 256
) (
    input  logic                       clk,
    input  logic                       en_i,
    input  logic                       we_i,
    input  logic [$clog2(WORDS)-1:0]   word_i,
    input  logic [LANE_BYTES-1:0]      be_i,
    input  logic [LANE_W-1:0]          wdata_i,
    output logic [LANE_W-1:0]          rdata_o
);
    logic [LANE_W-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (en_i) begin
            if (we_i) begin
                for (int b = 0; b < LANE_BYTES; b++)
                    if (be_i[b]) mem[word_i][b*8 +: 8] <= wdata_i[b*8 +: 8];
            end else begin
                rdata_o <= mem[word_i];
            end
        end
    end
endmodule

// File: rtl/banked_ram_xbar.sv
module banked_ram_xbar
    import xbar_pkg::*;
#(
    parameter int NUM_PORTS  = 4,
    parameter int NUM_BANKS  = 4,
    parameter int BANK_WORDS = 256,
    parameter int ADDR_W     = OFF_W + $clog2(BANK_WORDS) + $clog2(NUM_BANKS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_PORTS-1:0]        req_valid,
    input  logic [NUM_PORTS-1:0]        req_write,
    input  logic [2*NUM_PORTS-1:0]      req_size,
    input  logic [ADDR_W*NUM_PORTS-1:0] req_addr,
    input  logic [LANE_W*NUM_PORTS-1:0] req_wdata,
    output logic [NUM_PORTS-1:0]        req_stall,
    output logic [NUM_PORTS-1:0]        req_err,
    output logic [NUM_PORTS-1:0]        rsp_valid,
    output logic [LANE_W*NUM_PORTS-1:0] rsp_rdata
);
    localparam int BANK_W  = $clog2(NUM_BANKS);
    localparam int WORD_AW = $clog2(BANK_WORDS);

    typedef struct packed {
        logic [NUM_PORTS-1:0]             vld;
        logic [NUM_PORTS-1:0][BANK_W-1:0] bank;
        logic [NUM_PORTS-1:0][OFF_W-1:0]  off;
        logic [NUM_PORTS-1:0][1:0]        size;
    } rsp_state_t;

    rsp_state_t rs_d, rs_q;

    logic [BANK_W-1:0]     p_bank [NUM_PORTS];
    logic [WORD_AW-1:0]    p_word [NUM_PORTS];
    logic [LANE_BYTES-1:0] p_be   [NUM_PORTS];
    logic [LANE_W-1:0]     p_lane [NUM_PORTS];
    logic [NUM_PORTS-1:0]  p_err;
    logic [NUM_PORTS-1:0]  p_gnt;

    logic [NUM_PORTS-1:0]  b_req   [NUM_BANKS];
    logic [NUM_PORTS-1:0]  b_gnt   [NUM_BANKS];
    logic [NUM_BANKS-1:0]  b_en, b_we;
    logic [WORD_AW-1:0]    b_word  [NUM_BANKS];
    logic [LANE_BYTES-1:0] b_be    [NUM_BANKS];
    logic [LANE_W-1:0]     b_wdata [NUM_BANKS];
    logic [LANE_W-1:0]     b_rdata [NUM_BANKS];

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        xbar_port_decode #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .WORD_AW(WORD_AW)) dec_i (
            .addr_i  (req_addr[p*ADDR_W +: ADDR_W]),
            .size_i  (req_size[p*2 +: 2]),
            .wdata_i (req_wdata[p*LANE_W +: LANE_W]),
            .bank_o  (p_bank[p]),
            .word_o  (p_word[p]),
            .be_o    (p_be[p]),
            .lane_o  (p_lane[p]),
            .err_o   (p_err[p])
        );
    end

    // Route requests to banks and winners back to ports
    always_comb begin
        p_gnt = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            b_en[b] = 1'b0;  b_we[b] = 1'b0;
            b_word[b] = '0;  b_be[b] = '0;  b_wdata[b] = '0;
            for (int p = 0; p < NUM_PORTS; p++) begin
                b_req[b][p] = req_valid[p] && !p_err[p] && (p_bank[p] == BANK_W'(b));
                if (b_gnt[b][p]) begin
                    b_en[b]    = 1'b1;
                    b_we[b]    = req_write[p];
                    b_word[b]  = p_word[p];
                    b_be[b]    = p_be[p];
                    b_wdata[b] = p_lane[p];
                    p_gnt[p]   = 1'b1;
                end
            end
        end
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        xbar_rr_arbiter #(.NUM_PORTS(NUM_PORTS)) arb_i (
            .clk(clk), .rst_n(rst_n), .req_i(b_req[b]), .gnt_o(b_gnt[b])
        );
        xbar_bank_ram #(.WORDS(BANK_WORDS)) ram_i (
            .clk(clk), .en_i(b_en[b]), .we_i(b_we[b]), .word_i(b_word[b]),
            .be_i(b_be[b]), .wdata_i(b_wdata[b]), .rdata_o(b_rdata[b])
        );
    end

    // Next response state and output alignment
    always_comb begin : rsp_path
        logic [LANE_W-1:0] shifted, mask;
        rs_d = rs_q;
        for (int p = 0; p < NUM_PORTS; p++) begin
            rs_d.vld[p] = p_gnt[p] && !req_write[p];
            if (p_gnt[p]) begin
                rs_d.bank[p] = p_bank[p];
                rs_d.off[p]  = req_addr[p*ADDR_W +: OFF_W];
                rs_d.size[p] = req_size[p*2 +: 2];
            end
            shifted = b_rdata[rs_q.bank[p]] >> {rs_q.off[p], 3'b000};
            case (rs_q.size[p])
                2'd0:    mask = 64'h0000_0000_0000_00FF;
                2'd1:    mask = 64'h0000_0000_0000_FFFF;
                2'd2:    mask = 64'h0000_0000_FFFF_FFFF;
                default: mask = '1;
            endcase
            rsp_rdata[p*LANE_W +: LANE_W] = shifted & mask;
            req_stall[p] = req_valid[p] && !p_err[p] && !p_gnt[p];
            req_err[p]   = req_valid[p] && p_err[p];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rs_q <= '0;
        else        rs_q <= rs_d;
    end

    assign rsp_valid = rs_q.vld;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
        AST_READ_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
            (p_gnt[p] && !req_write[p]) |=> rsp_valid[p]); // R7
        AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid[p] && req_write[p] && !req_stall[p]) |=> !rsp_valid[p]); // R7
        AST_ERR_NOT_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
            req_err[p] |-> (!req_stall[p] && !p_gnt[p])); // R8
    end
endmodule

// File: tb/banked_ram_xbar_tb_top.sv
module banked_ram_xbar_tb_top;
    localparam int NP = 4;
    localparam int AW = 13;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NP-1:0]    req_valid = '0, req_write = '0;
    logic [2*NP-1:0]  req_size = '0;
    logic [AW*NP-1:0] req_addr = '0;
    logic [64*NP-1:0] req_wdata = '0;
    logic [NP-1:0]    req_stall, req_err, rsp_valid;
    logic [64*NP-1:0] rsp_rdata;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    banked_ram_xbar dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_stall(req_stall), .req_err(req_err), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata)
    );

    typedef struct packed {
        logic [1:0]  port;
        logic        wr;
        logic [1:0]  size;
        logic [12:0] addr;
        logic [63:0] wdata;
        logic [63:0] exp;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 1'b1, 2'd3, 13'h0000, 64'h1122334455667788, 64'h0},
        '{2'd1, 1'b0, 2'd3, 13'h0000, 64'h0, 64'h1122334455667788},
        '{2'd2, 1'b1, 2'd0, 13'h0003, 64'h00000000000000AB, 64'h0},
        '{2'd3, 1'b0, 2'd3, 13'h0000, 64'h0, 64'h11223344AB667788},
        '{2'd0, 1'b1, 2'd1, 13'h0006, 64'h000000000000BEEF, 64'h0},
        '{2'd1, 1'b0, 2'd1, 13'h0006, 64'h0, 64'h000000000000BEEF},
        '{2'd2, 1'b0, 2'd2, 13'h0004, 64'h0, 64'h00000000BEEF3344},
        '{2'd3, 1'b0, 2'd0, 13'h0001, 64'h0, 64'h0000000000000077},
        '{2'd0, 1'b1, 2'd3, 13'h0808, 64'h0102030405060708, 64'h0},
        '{2'd1, 1'b1, 2'd2, 13'h080C, 64'h00000000CAFEF00D, 64'h0},
        '{2'd2, 1'b0, 2'd3, 13'h0808, 64'h0, 64'hCAFEF00D05060708},
        '{2'd3, 1'b1, 2'd3, 13'h1800, 64'hFFFF0000FFFF0000, 64'h0},
        '{2'd0, 1'b0, 2'd3, 13'h1800, 64'h0, 64'hFFFF0000FFFF0000},
        '{2'd1, 1'b0, 2'd3, 13'h0000, 64'h0, 64'hBEEF3344AB667788},
        '{2'd2, 1'b1, 2'd3, 13'h1000, 64'h0F0E0D0C0B0A0908, 64'h0},
        '{2'd3, 1'b0, 2'd0, 13'h1007, 64'h0, 64'h000000000000000F}
    };

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic drive(input int p, input logic wr, input logic [1:0] sz,
                         input logic [12:0] a, input logic [63:0] d);
        req_write[p]        = wr;
        req_size[p*2 +: 2]  = sz;
        req_addr[p*AW +: AW] = a;
        req_wdata[p*64 +: 64] = d;
        req_valid[p]        = 1'b1;
    endtask

    function automatic logic [63:0] rd(input int p);
        return rsp_rdata[p*64 +: 64];
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        int prev;
        int win;
        logic [NP-1:0] seen;
        // R9: reset state
        repeat (3) @(negedge clk);
        check("R9 rsp_valid in reset", 64'(rsp_valid), 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 stall after reset", 64'(req_stall), 64'h0);
        check("R9 err after reset", 64'(req_err), 64'h0);
        check("R9 rsp_valid after reset", 64'(rsp_valid), 64'h0);

        // Vector table: single-port accesses (R1 R3 R7)
        for (int v = 0; v < NV; v++) begin
            drive(int'(VECS[v].port), VECS[v].wr, VECS[v].size, VECS[v].addr, VECS[v].wdata);
            #1;
            check($sformatf("R2 vector %0d not stalled", v), 64'(req_stall), 64'h0);
            @(posedge clk);
            @(negedge clk);
            req_valid = '0;
            if (VECS[v].wr) begin
                check($sformatf("R7 vector %0d write gives no rsp", v), 64'(rsp_valid), 64'h0);
            end else begin
                check($sformatf("R7 vector %0d rsp_valid", v), 64'(rsp_valid),
                      64'(4'b0001 << VECS[v].port));
                check($sformatf("R1 R3 vector %0d read data", v), rd(int'(VECS[v].port)), VECS[v].exp);
            end
        end

        // R2: four ports, four banks, same cycle
        drive(0, 1'b0, 2'd3, 13'h0000, 64'h0);
        drive(1, 1'b0, 2'd3, 13'h0808, 64'h0);
        drive(2, 1'b0, 2'd3, 13'h1800, 64'h0);
        drive(3, 1'b0, 2'd3, 13'h1000, 64'h0);
        #1;
        check("R2 parallel no stall", 64'(req_stall), 64'h0);
        @(posedge clk);
        @(negedge clk);
        req_valid = '0;
        check("R2 parallel rsp_valid", 64'(rsp_valid), 64'hF);
        check("R2 port0 data", rd(0), 64'hBEEF3344AB667788);
        check("R2 port1 data", rd(1), 64'hCAFEF00D05060708);
        check("R2 port2 data", rd(2), 64'hFFFF0000FFFF0000);
        check("R2 port3 data", rd(3), 64'h0F0E0D0C0B0A0908);

        // R4 R5 R6: all ports contend for bank 0
        for (int p = 0; p < NP; p++) drive(p, 1'b0, 2'd3, 13'h0000, 64'h0);
        prev = 0;
        seen = '0;
        for (int c = 0; c < NP; c++) begin
            #1;
            check("R4 one winner", 64'($countones(~req_stall)), 64'd1);
            win = 0;
            for (int p = 0; p < NP; p++) if (!req_stall[p]) win = p;
            if (c > 0) begin
                check("R5 cyclic order", 64'(win), 64'((prev + 1) % NP));
                check("R7 previous winner rsp_valid", 64'(rsp_valid), 64'(4'b0001 << prev));
                check("R7 previous winner data", rd(prev), 64'hBEEF3344AB667788);
            end
            seen[win] = 1'b1;
            prev = win;
            @(negedge clk);
        end
        req_valid = '0;
        check("R6 all ports served in NUM_PORTS cycles", 64'(seen), 64'hF);
        check("R7 last winner rsp_valid", 64'(rsp_valid), 64'(4'b0001 << prev));

        // R8: write crossing the word boundary is refused
        drive(0, 1'b1, 2'd2, 13'h0006, 64'h00000000DEADDEAD);
        #1;
        check("R8 err flag", 64'(req_err), 64'h1);
        check("R8 not stalled", 64'(req_stall), 64'h0);
        @(posedge clk);
        @(negedge clk);
        req_valid = '0;
        check("R8 no response", 64'(rsp_valid), 64'h0);
        drive(1, 1'b1, 2'd3, 13'h0804, 64'h0);
        #1;
        check("R8 64-bit misaligned err", 64'(req_err), 64'h2);
        @(posedge clk);
        @(negedge clk);
        req_valid = '0;
        drive(2, 1'b0, 2'd3, 13'h0000, 64'h0);
        @(posedge clk);
        @(negedge clk);
        req_valid = '0;
        check("R8 bank0 unchanged", rd(2), 64'hBEEF3344AB667788);
        drive(3, 1'b0, 2'd3, 13'h0800, 64'h0);
        @(posedge clk);
        @(negedge clk);
        req_valid = '0;
        drive(0, 1'b0, 2'd3, 13'h0808, 64'h0);
        @(posedge clk);
        @(negedge clk);
        req_valid = '0;
        check("R8 bank1 word unchanged", rd(0), 64'hCAFEF00D05060708);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule